// File: doc/BRIEF.md
# Floating-Point Status and Trap Unit

This block holds the 32-bit floating-point status word that sits beside an arithmetic datapath. At the end of each operation the datapath presents a five-bit exception vector with an update strobe. The unit records the vector as the latest exception set. It then compares the vector with the trap-enable field. If any enabled exception is present, it writes the IEEE trap-type code and sends a one-cycle trap request to the trap sequencer. If none is present, it merges the vector into the sticky accrued field instead.

Software can replace the status word with a masked load, which changes only the bits a write mask selects. The unit also decodes the word's two-bit rounding field into the rounding mode the datapath uses. A float-to-integer operation overrides that field and always gets truncation.

Top module: `fpsr_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads zero and no trap request is raised.
- R2: An update with a nonzero exception vector writes the vector into bits 4..0 of the status word. The bit order is invalid at 4, overflow at 3, underflow at 2, divide-by-zero at 1 and inexact at 0. The new value is visible from the next clock edge.
- R3: When the vector ANDed with the trap-enable field (bits 27..23, in the same bit order) is nonzero, the trap-type field (bits 16..14) becomes 3'b001. The trap request is high for exactly the one cycle after the updating edge.
- R4: When an update carries a nonzero vector and no enabled exception is present, the vector is ORed into the accrued field (bits 9..5). The trap-type field keeps its value.
- R5: When an update traps, the accrued field keeps its value.
- R6: An update whose vector is zero leaves the whole status word unchanged and raises no trap.
- R7: A software load replaces only the bits set in the write mask. With the default mask these are 31..30, 27..23 and 9..0. All other bits, the trap-type field among them, keep their old value.
- R8: When an update with a nonzero vector and a load arrive in the same cycle, the update is applied and the load is dropped.
- R9: The rounding output decodes bits 31..30 of the status word. Field value 0 gives nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity, and the output codes are the same numbers.
- R10: While the float-to-integer input is high, the rounding output is 1 (toward zero), whatever the rounding field holds.
- R11: A software load never raises the trap request, even when it writes both exception and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| updValid | input | 1 | Exception update strobe from the datapath |
| excFlags | input | 5 | Exception vector of the finishing operation |
| ldValid | input | 1 | Software load strobe |
| ldData | input | 32 | Software load value |
| opToInt | input | 1 | Current operation converts float to integer |
| fsrOut | output | 32 | Status word |
| roundMode | output | 2 | Rounding mode for the datapath |
| trapReq | output | 1 | One-cycle floating-point trap request |

## Verification
A wrong internal value shows up on the status-word port one edge after the update or load that produced it, so the bench compares that port on every cycle. A bad trap decision shows in two places in that same cycle: a missing or extra trap pulse, and an accrued field that grew when it should have held. A wrong rounding field shows on the rounding output in the same cycle it is stored.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int EXC_W     = 5;
  localparam int REG_W     = 32;
  localparam int CEXC_LSB  = 0;
  localparam int AEXC_LSB  = CEXC_LSB + EXC_W;
  localparam int TEM_LSB   = CEXC_LSB + 23;
  localparam int TTYPE_LSB = 14;
  localparam int TTYPE_W   = 3;
  localparam int RD_LSB    = 30;
  localparam int RD_W      = 2;

  localparam logic [TTYPE_W-1:0] TT_IEEE = 3'd1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } roundMode_e;

  typedef struct packed {
    logic writeCexc;
    logic accrue;
    logic setTrapType;
    logic softLoad;
  } fsrStrobe_t;
endpackage

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic [EXC_W-1:0] excFlags,
  input  logic             ldValid,
  input  logic [EXC_W-1:0] trapEn,
  output fsrStrobe_t       strb,
  output logic             trapReq
);
  logic anyExc;
  logic enabledHit;

  assign anyExc     = |excFlags;
  assign enabledHit = |(excFlags & trapEn);

  always_comb begin
    strb             = '0;
    strb.writeCexc   = updValid && anyExc;
    strb.setTrapType = strb.writeCexc && enabledHit;
    strb.accrue      = strb.writeCexc && !enabledHit;
    // an exception update outranks a software load in the same cycle
    strb.softLoad    = ldValid && !strb.writeCexc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= strb.setTrapType;
  end
endmodule

// File: rtl/fpsr_datapath.sv
module fpsr_datapath
  import fpsr_pkg::*;
#(
  parameter logic [REG_W-1:0] WR_MASK = 32'hCF80_03FF
)(
  input  logic             clk,
  input  logic             rstN,
  input  fsrStrobe_t       strb,
  input  logic [EXC_W-1:0] excFlags,
  input  logic [REG_W-1:0] ldData,
  input  logic             opToInt,
  output logic [EXC_W-1:0] trapEn,
  output logic [REG_W-1:0] fsrQ,
  output logic [RD_W-1:0]  roundMode
);
  logic [REG_W-1:0] fsrNxt;
  logic [EXC_W-1:0] cexcNxt;
  logic [EXC_W-1:0] aexcNxt;
  roundMode_e       rdDecoded;

  // per-bit exception capture and sticky accrual
  for (genvar i = 0; i < EXC_W; i++) begin : g_exc
    assign cexcNxt[i] = strb.writeCexc ? excFlags[i] : fsrQ[CEXC_LSB+i];
    assign aexcNxt[i] = strb.accrue ? (fsrQ[AEXC_LSB+i] | excFlags[i])
                                    : fsrQ[AEXC_LSB+i];
  end

  always_comb begin
    if (strb.softLoad) begin
      fsrNxt = (ldData & WR_MASK) | (fsrQ & ~WR_MASK);
    end else begin
      fsrNxt = fsrQ;
      fsrNxt[CEXC_LSB +: EXC_W] = cexcNxt;
      fsrNxt[AEXC_LSB +: EXC_W] = aexcNxt;
      if (strb.setTrapType) fsrNxt[TTYPE_LSB +: TTYPE_W] = TT_IEEE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsrQ <= '0;
    else       fsrQ <= fsrNxt;
  end

  assign trapEn = fsrQ[TEM_LSB +: EXC_W];

  always_comb begin
    unique case (fsrQ[RD_LSB +: RD_W])
      2'd0:    rdDecoded = RM_NEAR;
      2'd2:    rdDecoded = RM_UP;
      2'd3:    rdDecoded = RM_DOWN;
      default: rdDecoded = RM_ZERO;
    endcase
  end

  assign roundMode = opToInt ? RM_ZERO : rdDecoded;
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter logic [31:0] WR_MASK = 32'hCF80_03FF
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        updValid,
  input  logic [4:0]  excFlags,
  input  logic        ldValid,
  input  logic [31:0] ldData,
  input  logic        opToInt,
  output logic [31:0] fsrOut,
  output logic [1:0]  roundMode,
  output logic        trapReq
);
  fsrStrobe_t       strb;
  logic [EXC_W-1:0] trapEn;

  fpsr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .excFlags (excFlags),
    .ldValid  (ldValid),
    .trapEn   (trapEn),
    .strb     (strb),
    .trapReq  (trapReq)
  );

  fpsr_datapath #(.WR_MASK(WR_MASK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .excFlags  (excFlags),
    .ldData    (ldData),
    .opToInt   (opToInt),
    .trapEn    (trapEn),
    .fsrQ      (fsrOut),
    .roundMode (roundMode)
  );
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        updValid,
  input logic [4:0]  excFlags,
  input logic        ldValid,
  input logic        opToInt,
  input logic [31:0] fsrOut,
  input logic [1:0]  roundMode,
  input logic        trapReq
);
  AST_CEXC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && excFlags != 5'd0) |=> fsrOut[4:0] == $past(excFlags)); // R2
  AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> fsrOut[16:14] == 3'd1); // R3
  AST_TRAP_HOLDS_ACCRUED: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> fsrOut[9:5] == $past(fsrOut[9:5])); // R5
  AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !ldValid) |=> (fsrOut[9:5] & $past(fsrOut[9:5])) == $past(fsrOut[9:5])); // R4
  AST_ZERO_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && excFlags == 5'd0 && !ldValid) |=> ($stable(fsrOut) && !trapReq)); // R6
  AST_TRAP_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(updValid)); // R11
  AST_TOINT_TRUNC: assert property (@(posedge clk) disable iff (!rstN)
    opToInt |-> roundMode == 2'd1); // R10
endmodule

bind fpsr_unit fpsr_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updValid  (updValid),
  .excFlags  (excFlags),
  .ldValid   (ldValid),
  .opToInt   (opToInt),
  .fsrOut    (fsrOut),
  .roundMode (roundMode),
  .trapReq   (trapReq)
);

// File: tb/fpsr_unit_tb.sv
`timescale 1ns/1ps
module fpsr_unit_tb;
  localparam logic [31:0] MASK = 32'hCF80_03FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        updValid = 1'b0;
  logic [4:0]  excFlags = '0;
  logic        ldValid = 1'b0;
  logic [31:0] ldData = '0;
  logic        opToInt = 1'b0;
  logic [31:0] fsrOut;
  logic [1:0]  roundMode;
  logic        trapReq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    live = 0;
  string curReq = "R1";

  logic [31:0] mFsr = '0;
  logic        mTrap = 1'b0;

  always #2 clk = ~clk;

  fpsr_unit u_dut (
    .clk(clk), .rstN(rstN), .updValid(updValid), .excFlags(excFlags),
    .ldValid(ldValid), .ldData(ldData), .opToInt(opToInt),
    .fsrOut(fsrOut), .roundMode(roundMode), .trapReq(trapReq)
  );

  // behavioural reference, field positions taken from the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFsr = '0; mTrap = 1'b0;
    end else if (updValid && excFlags != 0) begin
      if ((excFlags & mFsr[27:23]) != 0) begin
        mFsr[16:14] = 3'd1; mTrap = 1'b1;
      end else begin
        mFsr[9:5] = mFsr[9:5] | excFlags; mTrap = 1'b0;
      end
      mFsr[4:0] = excFlags;
    end else begin
      mTrap = 1'b0;
      if (ldValid) mFsr = (ldData & MASK) | (mFsr & ~MASK);
    end
  end

  function automatic logic [1:0] expRound();
    if (opToInt) return 2'd1;
    return mFsr[31:30];
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live && !done) begin
    check("fsr", fsrOut, mFsr);
    check("trap", {31'd0, trapReq}, {31'd0, mTrap});
    check("round", {30'd0, roundMode}, {30'd0, expRound()});
  end

  task automatic step(input logic u, input logic [4:0] f, input logic l,
                      input logic [31:0] d, input logic ti);
    @(negedge clk); #1;
    updValid = u; excFlags = f; ldValid = l; ldData = d; opToInt = ti;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("reset fsr", fsrOut, 32'd0);
    check("reset trap", {31'd0, trapReq}, 32'd0);
    #1 rstN = 1'b1;
    live = 1;
    idle(); idle();
    // R9: each rounding field value
    curReq = "R9";
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1, {k[1:0], 30'd0}, 0); idle();
    end
    // R10: truncation override with nearest-even in the field
    curReq = "R10";
    step(0, 0, 1, 32'd0, 0); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); idle();
    // R2 and R4: no enables, capture and accrue
    curReq = "R2";
    step(1, 5'b10000, 0, 0, 0); idle();
    step(1, 5'b00001, 0, 0, 0); idle();
    curReq = "R4";
    step(1, 5'b01010, 0, 0, 0); step(1, 5'b00100, 0, 0, 0); idle();
    // R6: zero vector leaves everything
    curReq = "R6";
    step(1, 5'b00000, 0, 0, 0); idle(); idle();
    // R3 and R5: enable underflow (bit 25) and trap on it
    curReq = "R3";
    step(0, 0, 1, 32'h0200_0000, 0); idle();
    step(1, 5'b00110, 0, 0, 0); idle(); idle();
    curReq = "R5";
    step(1, 5'b00100, 0, 0, 0); step(1, 5'b00101, 0, 0, 0); idle();
    curReq = "R4";
    step(1, 5'b00001, 0, 0, 0); idle();
    // R7: load of all ones keeps the trap-type and unmasked bits
    curReq = "R7";
    step(0, 0, 1, 32'hFFFF_FFFF, 0); idle();
    step(0, 0, 1, 32'h0000_0000, 0); idle();
    // R8: update and load together
    curReq = "R8";
    step(1, 5'b01000, 1, 32'hC000_0000, 0); idle();
    step(1, 5'b00000, 1, 32'h8000_0000, 0); idle();
    // R11: load writing exceptions and enables raises no trap
    curReq = "R11";
    step(0, 0, 1, 32'h0F80_001F, 0); idle(); idle();
    curReq = "R3";
    step(1, 5'b10000, 0, 0, 0); idle();
    repeat (3) idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule